// File: doc/BRIEF.md
# Description-Table Walk Sequencer

This block steers one port's packets through a programmable chain of processing elements. A small local table holds one descriptor per element. A descriptor is either a match/action table, backed by an exact-match or a ternary memory, or a two-way conditional branch evaluated by an action unit. When a packet arrives the sequencer starts at a fixed entry and reads that descriptor. It then raises a lookup request that carries the element's memory class, its resolved address, its key selector and its match kind. It waits for the response and moves on to the successor element. A table names its successor in its own descriptor. A branch takes its successor from the outcome that the action unit returns. The walk ends on a null successor, which reports completion, or on an unusable descriptor, which reports an error.

Software reprograms the flow through a single write port. It can write a whole descriptor, change only a successor pointer, or retire an entry. Each operation lands on one clock edge. A packet reads each descriptor exactly once, when it arrives at that entry. Because of this, tables and branches can be spliced in or bypassed while traffic flows, and no packet ever sees half of an update.

Top module: `pdt_seq`

## Requirements
- R1: After reset the block is idle: busy, request, done and error are all low, and every table entry is unpopulated.
- R2: A start pulse while idle begins a walk whose first lookup names entry index 0. A start pulse while a walk is in progress is ignored.
- R3: The request carries the memory class taken from the entry kind: kind 0 gives class 0 (exact-match memory), kind 1 gives class 1 (ternary memory) and kind 2 gives class 2 (action memory). It also carries the address, which is region base plus offset modulo 2^AW, and it passes the key selector and the match kind through unchanged.
- R4: A raised request holds its entry index steady until a cycle in which acknowledge is high. The next entry is read only after that acknowledge.
- R5: For a table entry the successor is its stored next pointer. The all-ones index means null: a null successor ends the walk, done pulses for one cycle in the cycle after the acknowledge, and busy falls in that same cycle.
- R6: For a branch entry (kind 2) the stored next pointer is ignored. A true outcome selects the true jump index and a false outcome selects the false jump index. A null jump index ends the walk as in R5.
- R7: Reading an unpopulated entry, or an entry of kind 3, raises no request. Instead, error pulses for one cycle in the cycle after the read, and the walk ends.
- R8: An entry whose offset is greater than or equal to its region size raises no request and ends the walk with an error pulse, as in R7.
- R9: Control operations land on one edge. Op 1 writes a whole descriptor and marks it populated. Op 2 replaces only the next-pointer field. Op 3 marks the entry unpopulated. The descriptor bit layout is: next in [IW-1:0], offset above it, then size, then base (each AW bits), then key (KW bits), then match kind (2 bits), and finally kind in the top 2 bits.
- R10: A walk uses the descriptor contents that were present when it read that entry. A write to the current entry after that read does not change the current step. A write to a later entry that lands before that entry is read is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk for a new packet |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse: walk reached a null successor |
| err_o | output | 1 | One-cycle pulse: walk hit an unusable entry |
| cfg_op_i | input | 2 | Control operation: 0 none, 1 write, 2 set next, 3 clear |
| cfg_idx_i | input | IW | Entry index for the control operation |
| cfg_entry_i | input | EW | Descriptor data; low IW bits alone for set next |
| lk_req_o | output | 1 | Lookup request valid |
| lk_idx_o | output | IW | Entry index being serviced |
| lk_tgt_o | output | 2 | Memory class of the request |
| lk_addr_o | output | AW | Resolved address, base plus offset |
| lk_key_o | output | KW | Match key selector |
| lk_mkind_o | output | 2 | Match kind |
| lk_ack_i | input | 1 | Lookup response valid |
| lk_cond_i | input | 1 | Branch outcome (used for branch entries) |
| lk_jmp_t_i | input | IW | Jump index taken on a true outcome |
| lk_jmp_f_i | input | IW | Jump index taken on a false outcome |

## Verification
The bench builds the block with 64 entries, which gives a 6-bit index with index 63 as null and leaves 63 usable entries. It uses a 12-bit address and an 8-bit key selector. With 12 bits, base plus offset can wrap, and regions can be drawn so that the offset lands exactly on the size. Random programs point only forward, so every walk ends, and those walks can still reach every usable index. Successor writes land at random moments during waits, which covers both the current-entry and the later-entry cases.

// File: rtl/pdt_seq_pkg.sv
package pdt_seq_pkg;

  // descriptor kinds; request memory class uses the same code
  localparam logic [1:0] KIND_SRAM   = 2'd0;
  localparam logic [1:0] KIND_TCAM   = 2'd1;
  localparam logic [1:0] KIND_BRANCH = 2'd2;
  localparam logic [1:0] KIND_RSVD   = 2'd3;

  // control operations
  localparam logic [1:0] OP_NOP   = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_NEXT  = 2'd2;
  localparam logic [1:0] OP_CLEAR = 2'd3;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_FETCH,
    WS_REQ
  } walk_state_e;

endpackage

// File: rtl/pdt_store.sv
module pdt_store
  import pdt_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IW    = 6,
  parameter int HW    = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    wr_op_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [HW-1:0] wr_hi_i,
  input  logic [IW-1:0] wr_nx_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [HW-1:0] rd_hi_o,
  output logic [IW-1:0] rd_nx_o,
  output logic          rd_ok_o
);

  logic [DEPTH-1:0] row_hit;
  logic [DEPTH-1:0] hi_en;
  logic [DEPTH-1:0] nx_en;
  logic [DEPTH-1:0] ok_d;
  logic [DEPTH-1:0] ok_q;
  logic [HW-1:0]    hi_q [DEPTH];
  logic [IW-1:0]    nx_q [DEPTH];
  logic             rd_in_range;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_row
      assign row_hit[g] = (wr_idx_i == IW'(g));
      assign hi_en[g]   = row_hit[g] && (wr_op_i == OP_WRITE);
      assign nx_en[g]   = row_hit[g] && ((wr_op_i == OP_WRITE) || (wr_op_i == OP_NEXT));
    end
  endgenerate

  // populated flags: next state
  always_comb begin
    ok_d = ok_q;
    for (int r = 0; r < DEPTH; r++) begin
      if (hi_en[r]) begin
        ok_d[r] = 1'b1;
      end else if (row_hit[r] && (wr_op_i == OP_CLEAR)) begin
        ok_d[r] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= '0;
    end else begin
      ok_q <= ok_d;
    end
  end

  // descriptor storage, one clock enable per row and field group
  always_ff @(posedge clk) begin
    for (int r = 0; r < DEPTH; r++) begin
      if (hi_en[r]) begin
        hi_q[r] <= wr_hi_i;
      end
      if (nx_en[r]) begin
        nx_q[r] <= wr_nx_i;
      end
    end
  end

  assign rd_in_range = (32'(rd_idx_i) < DEPTH);
  assign rd_ok_o     = rd_in_range && ok_q[rd_idx_i];
  assign rd_hi_o     = hi_q[rd_idx_i];
  assign rd_nx_o     = nx_q[rd_idx_i];

endmodule

// File: rtl/pdt_decode.sv
module pdt_decode
  import pdt_seq_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  input  logic [AW-1:0] off_i,
  output logic [1:0]    tgt_o,
  output logic [AW-1:0] addr_o,
  output logic          fault_o,
  output logic          branch_o
);

  logic out_of_region;
  logic bad_kind;

  assign out_of_region = (off_i >= size_i);
  assign bad_kind      = (kind_i == KIND_RSVD);
  assign fault_o       = out_of_region || bad_kind;
  assign branch_o      = (kind_i == KIND_BRANCH);
  assign tgt_o         = kind_i;
  assign addr_o        = base_i + off_i;

endmodule

// File: rtl/pdt_walk_fsm.sv
module pdt_walk_fsm
  import pdt_seq_pkg::*;
#(
  parameter int            IW    = 6,
  parameter int            AW    = 12,
  parameter int            KW    = 8,
  parameter logic [IW-1:0] START = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ent_ok_i,
  input  logic          fault_i,
  input  logic [1:0]    tgt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [KW-1:0] key_i,
  input  logic [1:0]    mk_i,
  input  logic [IW-1:0] nx_i,
  input  logic          br_i,
  input  logic          ack_i,
  input  logic          cond_i,
  input  logic [IW-1:0] jt_i,
  input  logic [IW-1:0] jf_i,
  output logic [IW-1:0] rd_idx_o,
  output logic          req_o,
  output logic [1:0]    tgt_o,
  output logic [AW-1:0] addr_o,
  output logic [KW-1:0] key_o,
  output logic [1:0]    mk_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);

  localparam logic [IW-1:0] NULL_IDX = '1;

  walk_state_e   st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] succ;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          cap_en;

  logic [1:0]    tgt_q;
  logic [AW-1:0] addr_q;
  logic [KW-1:0] key_q;
  logic [1:0]    mk_q;
  logic [IW-1:0] nx_q;
  logic          br_q;

  // next state
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    cap_en = 1'b0;
    succ   = br_q ? (cond_i ? jt_i : jf_i) : nx_q;
    unique case (st_q)
      WS_IDLE: begin
        if (start_i) begin
          idx_d = START;
          st_d  = WS_FETCH;
        end
      end
      WS_FETCH: begin
        if (!ent_ok_i || fault_i) begin
          err_d = 1'b1;
          st_d  = WS_IDLE;
        end else begin
          cap_en = 1'b1;
          st_d   = WS_REQ;
        end
      end
      WS_REQ: begin
        if (ack_i) begin
          if (succ == NULL_IDX) begin
            done_d = 1'b1;
            st_d   = WS_IDLE;
          end else begin
            idx_d = succ;
            st_d  = WS_FETCH;
          end
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      idx_q  <= START;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // descriptor snapshot taken once per visit
  always_ff @(posedge clk) begin
    if (cap_en) begin
      tgt_q  <= tgt_i;
      addr_q <= addr_i;
      key_q  <= key_i;
      mk_q   <= mk_i;
      nx_q   <= nx_i;
      br_q   <= br_i;
    end
  end

  assign rd_idx_o = idx_q;
  assign req_o    = (st_q == WS_REQ);
  assign busy_o   = (st_q != WS_IDLE);
  assign tgt_o    = tgt_q;
  assign addr_o   = addr_q;
  assign key_o    = key_q;
  assign mk_o     = mk_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

endmodule

// File: rtl/pdt_seq.sv
module pdt_seq
  import pdt_seq_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int AW    = 12,
  parameter  int KW    = 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int EW    = 4 + KW + 3 * AW + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  input  logic [1:0]    cfg_op_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic [EW-1:0] cfg_entry_i,
  output logic          lk_req_o,
  output logic [IW-1:0] lk_idx_o,
  output logic [1:0]    lk_tgt_o,
  output logic [AW-1:0] lk_addr_o,
  output logic [KW-1:0] lk_key_o,
  output logic [1:0]    lk_mkind_o,
  input  logic          lk_ack_i,
  input  logic          lk_cond_i,
  input  logic [IW-1:0] lk_jmp_t_i,
  input  logic [IW-1:0] lk_jmp_f_i
);

  localparam int HW     = EW - IW;
  localparam int OFF_LO = IW;
  localparam int SZ_LO  = OFF_LO + AW;
  localparam int BS_LO  = SZ_LO + AW;
  localparam int KEY_LO = BS_LO + AW;
  localparam int MK_LO  = KEY_LO + KW;
  localparam int KD_LO  = MK_LO + 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IW-1:0] rd_idx;
  logic [HW-1:0] rd_hi;
  logic [IW-1:0] rd_nx;
  logic          rd_ok;
  logic [EW-1:0] rd_ent;

  pdt_store #(
    .DEPTH (DEPTH),
    .IW    (IW),
    .HW    (HW)
  ) store_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_op_i  (cfg_op_i),
    .wr_idx_i (cfg_idx_i),
    .wr_hi_i  (cfg_entry_i[EW-1:IW]),
    .wr_nx_i  (cfg_entry_i[IW-1:0]),
    .rd_idx_i (rd_idx),
    .rd_hi_o  (rd_hi),
    .rd_nx_o  (rd_nx),
    .rd_ok_o  (rd_ok)
  );

  assign rd_ent = {rd_hi, rd_nx};

  logic [1:0]    dec_tgt;
  logic [AW-1:0] dec_addr;
  logic          dec_fault;
  logic          dec_br;

  pdt_decode #(
    .AW (AW)
  ) decode_i (
    .kind_i   (rd_ent[KD_LO +: 2]),
    .base_i   (rd_ent[BS_LO +: AW]),
    .size_i   (rd_ent[SZ_LO +: AW]),
    .off_i    (rd_ent[OFF_LO +: AW]),
    .tgt_o    (dec_tgt),
    .addr_o   (dec_addr),
    .fault_o  (dec_fault),
    .branch_o (dec_br)
  );

  pdt_walk_fsm #(
    .IW    (IW),
    .AW    (AW),
    .KW    (KW),
    .START ('0)
  ) walk_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .ent_ok_i (rd_ok),
    .fault_i  (dec_fault),
    .tgt_i    (dec_tgt),
    .addr_i   (dec_addr),
    .key_i    (rd_ent[KEY_LO +: KW]),
    .mk_i     (rd_ent[MK_LO +: 2]),
    .nx_i     (rd_nx),
    .br_i     (dec_br),
    .ack_i    (lk_ack_i),
    .cond_i   (lk_cond_i),
    .jt_i     (lk_jmp_t_i),
    .jf_i     (lk_jmp_f_i),
    .rd_idx_o (rd_idx),
    .req_o    (lk_req_o),
    .tgt_o    (lk_tgt_o),
    .addr_o   (lk_addr_o),
    .key_o    (lk_key_o),
    .mk_o     (lk_mkind_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  assign lk_idx_o = rd_idx;

endmodule

// File: rtl/pdt_seq_chk.sv
module pdt_seq_chk #(
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          lk_req_o,
  input logic          lk_ack_i,
  input logic [IW-1:0] lk_idx_o,
  input logic [1:0]    lk_tgt_o
);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req_o && !lk_ack_i) |=> (lk_req_o && $stable(lk_idx_o)));

  // R5
  end_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o}));

  // R5
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> !busy_o);

  // R5
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(lk_ack_i) && $past(lk_req_o)));

  // R3
  tgt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_o |-> (lk_tgt_o != 2'b11));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R7
  err_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!lk_req_o && !$past(lk_req_o)));

endmodule

bind pdt_seq pdt_seq_chk #(.IW(IW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .lk_req_o (lk_req_o),
  .lk_ack_i (lk_ack_i),
  .lk_idx_o (lk_idx_o),
  .lk_tgt_o (lk_tgt_o)
);

// File: tb/pdt_seq_tb_top.sv
module pdt_seq_tb_top;

  localparam int DEPTH = 64;
  localparam int IW    = 6;
  localparam int AW    = 12;
  localparam int KW    = 8;
  localparam int EW    = 4 + KW + 3 * AW + IW;
  localparam logic [IW-1:0] NUL = '1;

  logic          clk, rst_n, start_i, busy_o, done_o, err_o;
  logic [1:0]    cfg_op_i;
  logic [IW-1:0] cfg_idx_i;
  logic [EW-1:0] cfg_entry_i;
  logic          lk_req_o;
  logic [IW-1:0] lk_idx_o;
  logic [1:0]    lk_tgt_o;
  logic [AW-1:0] lk_addr_o;
  logic [KW-1:0] lk_key_o;
  logic [1:0]    lk_mkind_o;
  logic          lk_ack_i, lk_cond_i;
  logic [IW-1:0] lk_jmp_t_i, lk_jmp_f_i;

  pdt_seq #(.DEPTH(DEPTH), .AW(AW), .KW(KW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .cfg_op_i(cfg_op_i),
    .cfg_idx_i(cfg_idx_i), .cfg_entry_i(cfg_entry_i), .lk_req_o(lk_req_o),
    .lk_idx_o(lk_idx_o), .lk_tgt_o(lk_tgt_o), .lk_addr_o(lk_addr_o),
    .lk_key_o(lk_key_o), .lk_mkind_o(lk_mkind_o), .lk_ack_i(lk_ack_i),
    .lk_cond_i(lk_cond_i), .lk_jmp_t_i(lk_jmp_t_i), .lk_jmp_f_i(lk_jmp_f_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk;
  int n_fail;
  bit finished;

  // bench shadow of the table
  bit            m_ok   [DEPTH];
  logic [1:0]    m_kind [DEPTH];
  logic [1:0]    m_mk   [DEPTH];
  logic [KW-1:0] m_key  [DEPTH];
  logic [AW-1:0] m_base [DEPTH];
  logic [AW-1:0] m_size [DEPTH];
  logic [AW-1:0] m_off  [DEPTH];
  logic [IW-1:0] m_nx   [DEPTH];

  bit            f_on, f_c, dir_mw;
  logic [IW-1:0] f_t, f_f;
  int            mw_prob;
  int            vis[$];
  int            last_out;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] pick_succ(int i);
    int span;
    if (i >= DEPTH - 2 || ($urandom % 4) == 0) return NUL;
    span = ((DEPTH - 2 - i) < 6) ? (DEPTH - 2 - i) : 6;
    return IW'(i + 1 + int'($urandom % span));
  endfunction

  task automatic cfg_wr(int idx, logic [1:0] kind, logic [1:0] mk, logic [KW-1:0] key,
                        logic [AW-1:0] base, logic [AW-1:0] size, logic [AW-1:0] off,
                        logic [IW-1:0] nx);
    cfg_op_i    = 2'd1;
    cfg_idx_i   = IW'(idx);
    cfg_entry_i = {kind, mk, key, base, size, off, nx};
    @(negedge clk);
    cfg_op_i = 2'd0;
    m_ok[idx] = 1'b1; m_kind[idx] = kind; m_mk[idx] = mk; m_key[idx] = key;
    m_base[idx] = base; m_size[idx] = size; m_off[idx] = off; m_nx[idx] = nx;
  endtask

  task automatic cfg_nx(int idx, logic [IW-1:0] nx);
    cfg_op_i    = 2'd2;
    cfg_idx_i   = IW'(idx);
    cfg_entry_i = {$urandom, $urandom} ;
    cfg_entry_i[IW-1:0] = nx;
    @(negedge clk);
    cfg_op_i = 2'd0;
    m_nx[idx] = nx;
  endtask

  task automatic cfg_clr(int idx);
    cfg_op_i  = 2'd3;
    cfg_idx_i = IW'(idx);
    @(negedge clk);
    cfg_op_i = 2'd0;
    m_ok[idx] = 1'b0;
  endtask

  task automatic rand_entry(int i);
    int r;
    logic [1:0] kind;
    logic [AW-1:0] size, off;
    r = int'($urandom % 24);
    if (r == 0) begin
      cfg_clr(i);
    end else begin
      kind = (r == 1) ? 2'd3 : ((r < 8) ? 2'd2 : ((r % 2) ? 2'd1 : 2'd0));
      size = AW'(1 + int'($urandom % 4000));
      if (($urandom % 16) == 0) off = AW'(int'(size) + int'($urandom % (4096 - int'(size))));
      else off = AW'($urandom % int'(size));
      cfg_wr(i, kind, 2'($urandom), KW'($urandom), AW'($urandom), size, off, pick_succ(i));
    end
  endtask

  // one packet walk; starts and ends on a falling edge
  task automatic run_pkt();
    int cur;
    int d;
    int j;
    bit c, wrote_cur;
    logic [IW-1:0] t, f, nx, own_nx;
    logic [1:0] kind;
    vis.delete();
    last_out = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cur = 0;
    for (int hops = 0; hops < DEPTH + 2; hops++) begin
      if (!m_ok[cur] || m_kind[cur] == 2'd3 || m_off[cur] >= m_size[cur]) begin
        @(negedge clk);
        check(err_o === 1'b1, (m_ok[cur] && m_kind[cur] != 2'd3) ? "R8" : "R7", "err pulse", err_o, 1);
        check(lk_req_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R7", "idle no req", {lk_req_o, busy_o, done_o}, 0);
        vis.push_back(cur);
        last_out = 2;
        @(negedge clk);
        check(err_o === 1'b0, "R7", "err one cycle", err_o, 0);
        return;
      end
      kind   = m_kind[cur];
      own_nx = m_nx[cur];
      @(negedge clk);
      vis.push_back(cur);
      check(lk_req_o === 1'b1, "R4", "req raised", lk_req_o, 1);
      check(lk_idx_o == IW'(cur), (hops == 0) ? "R2" : "R5", "req index", lk_idx_o, cur);
      check(lk_tgt_o == kind, "R3", "class", lk_tgt_o, kind);
      check(lk_addr_o == AW'(m_base[cur] + m_off[cur]), "R3", "addr", lk_addr_o, AW'(m_base[cur] + m_off[cur]));
      check(lk_key_o == m_key[cur] && lk_mkind_o == m_mk[cur], "R3", "key/kind", {lk_key_o, lk_mkind_o}, {m_key[cur], m_mk[cur]});
      wrote_cur = 1'b0;
      if (dir_mw && hops == 0) begin
        cfg_nx(0, 6'd2);
        cfg_nx(1, 6'd2);
        wrote_cur = 1'b1;
      end
      d = int'($urandom % 3);
      for (int w = 0; w < d; w++) begin
        if (int'($urandom % 100) < mw_prob) begin
          j = cur + int'($urandom % (DEPTH - 1 - cur));
          if (j == cur) wrote_cur = 1'b1;
          cfg_nx(j, pick_succ(j));
        end else begin
          start_i = 1'b1;
          @(negedge clk);
          start_i = 1'b0;
        end
        check(lk_req_o === 1'b1 && lk_idx_o == IW'(cur), "R4", "req held", {lk_req_o, lk_idx_o}, {1'b1, IW'(cur)});
      end
      if (f_on) begin
        c = f_c; t = f_t; f = f_f;
      end else begin
        c = 1'($urandom); t = pick_succ(cur); f = pick_succ(cur);
      end
      lk_ack_i = 1'b1; lk_cond_i = c; lk_jmp_t_i = t; lk_jmp_f_i = f;
      @(negedge clk);
      lk_ack_i = 1'b0;
      lk_jmp_t_i = IW'($urandom); lk_jmp_f_i = IW'($urandom);
      nx = (kind == 2'd2) ? (c ? t : f) : own_nx;
      if (nx == NUL) begin
        check(done_o === 1'b1 && busy_o === 1'b0, (kind == 2'd2) ? "R6" : "R5", "done at null", {done_o, busy_o}, 2'b10);
        check(err_o === 1'b0, "R5", "no err at done", err_o, 0);
        last_out = 1;
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0 && lk_req_o === 1'b0, "R2", "idle after done", {done_o, busy_o, lk_req_o}, 0);
        return;
      end
      check(busy_o === 1'b1 && lk_req_o === 1'b0 && done_o === 1'b0,
            wrote_cur ? "R10" : ((kind == 2'd2) ? "R6" : "R5"), "move to fetch", {busy_o, lk_req_o, done_o}, 3'b100);
      cur = int'(nx);
    end
    check(1'b0, "R5", "walk too long", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    n_chk = 0; n_fail = 0; finished = 1'b0;
    f_on = 0; f_c = 0; f_t = NUL; f_f = NUL; dir_mw = 0; mw_prob = 0;
    for (int i = 0; i < DEPTH; i++) m_ok[i] = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; cfg_op_i = 2'd0; cfg_idx_i = '0; cfg_entry_i = '0;
    lk_ack_i = 1'b0; lk_cond_i = 1'b0; lk_jmp_t_i = '0; lk_jmp_f_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs, empty table
    check(busy_o === 1'b0 && lk_req_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0,
          "R1", "reset outputs", {busy_o, lk_req_o, done_o, err_o}, 0);
    run_pkt();
    check(last_out == 2 && vis.size() == 1, "R1", "empty table errors", last_out, 2);

    // R3, R5: two-table chain with address wrap
    cfg_wr(0, 2'd0, 2'd1, 8'h5A, 12'hFF0, 12'h100, 12'h020, 6'd5);
    cfg_wr(5, 2'd1, 2'd2, 8'hC3, 12'h123, 12'h010, 12'h00F, NUL);
    run_pkt();
    check(last_out == 1 && vis.size() == 2 && vis[1] == 5, "R5", "chain 0-5", vis.size(), 2);

    // R6: branch ignores its stored next pointer
    cfg_wr(0, 2'd2, 2'd0, 8'h01, 12'h040, 12'h008, 12'h003, 6'd5);
    cfg_wr(7, 2'd0, 2'd3, 8'h77, 12'h200, 12'h020, 12'h001, NUL);
    f_on = 1; f_c = 1; f_t = NUL; f_f = 6'd5;
    run_pkt();
    check(last_out == 1 && vis.size() == 1, "R6", "true to null", vis.size(), 1);
    f_c = 0; f_t = 6'd5; f_f = 6'd7;
    run_pkt();
    check(last_out == 1 && vis.size() == 2 && vis[1] == 7, "R6", "false jump", vis.size(), 2);
    f_on = 0;

    // R8: offset at size faults, one below does not
    cfg_wr(0, 2'd0, 2'd0, 8'h10, 12'h300, 12'h010, 12'h010, NUL);
    run_pkt();
    check(last_out == 2, "R8", "offset == size", last_out, 2);
    cfg_wr(0, 2'd0, 2'd0, 8'h10, 12'h300, 12'h010, 12'h00F, NUL);
    run_pkt();
    check(last_out == 1, "R8", "offset == size-1", last_out, 1);

    // R7: reserved kind, then cleared entry
    cfg_wr(0, 2'd3, 2'd0, 8'h00, 12'h000, 12'h010, 12'h000, NUL);
    run_pkt();
    check(last_out == 2, "R7", "reserved kind", last_out, 2);
    cfg_wr(0, 2'd1, 2'd0, 8'h00, 12'h000, 12'h010, 12'h000, NUL);
    cfg_clr(0);
    run_pkt();
    check(last_out == 2, "R7", "cleared entry", last_out, 2);

    // R9: set-next keeps the other fields
    cfg_wr(0, 2'd1, 2'd2, 8'hA5, 12'h456, 12'h080, 12'h011, NUL);
    cfg_wr(9, 2'd0, 2'd1, 8'h3C, 12'h010, 12'h004, 12'h002, NUL);
    cfg_nx(0, 6'd9);
    run_pkt();
    check(last_out == 1 && vis.size() == 2 && vis[1] == 9, "R9", "set next", vis.size(), 2);

    // R10: write to current entry unseen, write to later entry seen
    cfg_wr(0, 2'd0, 2'd0, 8'h01, 12'h000, 12'h010, 12'h001, 6'd1);
    cfg_wr(1, 2'd0, 2'd0, 8'h02, 12'h000, 12'h010, 12'h002, NUL);
    cfg_wr(2, 2'd1, 2'd0, 8'h03, 12'h000, 12'h010, 12'h003, NUL);
    dir_mw = 1;
    run_pkt();
    dir_mw = 0;
    check(vis.size() == 3 && vis[1] == 1 && vis[2] == 2, "R10", "path 0-1-2", vis.size(), 3);

    // random programs with random successor writes during waits
    mw_prob = 25;
    for (int p = 0; p < 40; p++) begin
      for (int i = 0; i < DEPTH - 1; i++) rand_entry(i);
      for (int k = 0; k < 4; k++) run_pkt();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule